// File: doc/BRIEF.md
# Privilege and Exception State Controller

This block sits beside a CPU core and keeps two pieces of state: the processing state (normal, exception, halted, with stopped as a sub-condition of normal) and the supervisor bit. The core reports events as one-cycle strobes: executed instructions (stop, privileged, status-register write, return-from-exception), bus faults, interrupt and trap requests, and the completion of a reset or exception sequence. The controller decides the next state, whether the instruction is a privilege violation, and what privilege level is in force.

For every bus reference, the block also produces a 3-bit function code that tells external memory management which address space is being accessed. The core names the kind of access (data, program or interrupt acknowledge). The code then follows from that kind and the current privilege level. While the core is stopped or halted, no reference is classified.

Top module: `cpu_priv_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on release: state_o is exception (2'b01), supv_o = 1, saved_s_o = 1, stopped_o = 0, halted_o = 0. In this reset sequence, exc_done_i is ignored; reset_done_i moves state_o to normal (2'b00) on the next clock.
- R2: In normal and not stopped, irq_i or trap_i moves state_o to exception on the next clock. In exception that did not start from reset, exc_done_i returns state_o to normal on the next clock.
- R3: On every entry into exception processing, saved_s_o takes the supervisor bit held just before entry, and supv_o becomes 1 on the same clock.
- R4: bus_err_i in normal moves state_o to exception as bus-error handling. A further bus_err_i during bus-error handling, or during the reset sequence, moves state_o to halted (2'b10). A bus_err_i during any other exception keeps state_o at exception and converts it to bus-error handling.
- R5: Halted holds halted_o = 1 and ignores every input until `rst_ni` is asserted.
- R6: stop_exec_i with supv_o = 1 in normal sets stopped_o while state_o stays normal. While stopped, trap_i, bus_err_i and all instruction strobes are ignored. irq_i clears stopped_o and enters exception.
- R7: In normal, not stopped, with supv_o = 0, any of priv_instr_i, stop_exec_i, sr_wr_i or rte_i raises priv_viol_o in the same cycle. The instruction has no effect, and state_o is exception on the next clock.
- R8: In normal with supv_o = 1, sr_wr_i loads supv_o from sr_wr_s_i, and rte_i loads it from rte_s_i, on the next clock. sr_wr_i wins if both are high. In user mode the supervisor bit never rises except through exception entry.
- R9: ssp_sel_o equals supv_o at all times (1 selects the supervisor stack pointer).
- R10: fc_o is combinational. It is 000 when bus_valid_i = 0, when stopped, or when halted. Otherwise, with acc_kind_i 00 = data, 01 = program, 10 = interrupt acknowledge, 11 = no reference, the codes are:
  - user data 001, user program 010
  - supervisor data 101, supervisor program 110
  - interrupt acknowledge 111
  - no reference 000

  Codes 011 and 100 never appear.
- R11: In normal and not stopped, events take effect in this priority order:
  - bus_err_i
  - privilege violation, irq_i or trap_i
  - stop_exec_i
  - sr_wr_i or rte_i

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; starts the reset sequence |
| bus_err_i | input | 1 | Bus fault reported |
| irq_i | input | 1 | Interrupt request |
| trap_i | input | 1 | Trap request |
| stop_exec_i | input | 1 | Core executed a stop instruction |
| priv_instr_i | input | 1 | Core executed another privileged instruction |
| sr_wr_i | input | 1 | Core wrote the whole status register |
| sr_wr_s_i | input | 1 | Supervisor bit of the written status value |
| rte_i | input | 1 | Core executed return-from-exception |
| rte_s_i | input | 1 | Supervisor bit of the restored status value |
| reset_done_i | input | 1 | Reset sequence finished |
| exc_done_i | input | 1 | Exception sequence finished |
| bus_valid_i | input | 1 | Bus reference in progress |
| acc_kind_i | input | 2 | Access kind: 00 data, 01 program, 10 interrupt acknowledge, 11 none |
| state_o | output | 2 | 00 normal, 01 exception, 10 halted |
| stopped_o | output | 1 | Stopped sub-condition of normal |
| supv_o | output | 1 | Supervisor bit |
| saved_s_o | output | 1 | Supervisor bit captured at last exception entry |
| ssp_sel_o | output | 1 | 1 selects supervisor stack pointer, 0 user stack pointer |
| priv_viol_o | output | 1 | Privilege-violation request |
| fc_o | output | 3 | Function code of the current reference |
| halted_o | output | 1 | Halted indicator |

## Verification
priv_viol_o and fc_o depend combinationally on the present inputs, so they are compared in the same cycle that the stimulus is applied. A state change, a supervisor-bit update or a saved-bit capture caused by a strobe takes one register stage and is compared in the cycle after the clock edge that sampled it. The bench drives inputs on the falling edge and compares every output a quarter period later against a behavioural model. The model advances only after the rising edge, so each result is checked exactly in the cycle it is due.

// File: rtl/cpu_priv_pkg.sv
package cpu_priv_pkg;
  localparam int FC_W  = 3;
  localparam int ST_W  = 2;
  localparam int ACC_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_NORMAL = 2'd0,
    ST_EXCEPT = 2'd1,
    ST_HALTED = 2'd2
  } proc_state_e;

  typedef enum logic [1:0] {
    CAUSE_RESET = 2'd0,
    CAUSE_BERR  = 2'd1,
    CAUSE_OTHER = 2'd2
  } exc_cause_e;

  typedef enum logic [ACC_W-1:0] {
    ACC_DATA = 2'd0,
    ACC_PROG = 2'd1,
    ACC_IACK = 2'd2,
    ACC_NONE = 2'd3
  } acc_kind_e;

  localparam logic [FC_W-1:0] FC_NONE  = 3'b000;
  localparam logic [FC_W-1:0] FC_UDATA = 3'b001;
  localparam logic [FC_W-1:0] FC_UPROG = 3'b010;
  localparam logic [FC_W-1:0] FC_SDATA = 3'b101;
  localparam logic [FC_W-1:0] FC_SPROG = 3'b110;
  localparam logic [FC_W-1:0] FC_CPU   = 3'b111;
endpackage

// File: rtl/priv_state_fsm.sv
module priv_state_fsm
  import cpu_priv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        supv_i,
  input  logic        bus_err_i,
  input  logic        irq_i,
  input  logic        trap_i,
  input  logic        stop_exec_i,
  input  logic        priv_instr_i,
  input  logic        sr_wr_i,
  input  logic        rte_i,
  input  logic        reset_done_i,
  input  logic        exc_done_i,
  output proc_state_e state_o,
  output logic        stopped_o,
  output logic        priv_viol_o,
  output logic        exc_enter_o,
  output logic        sr_load_o,
  output logic        rte_load_o
);
  proc_state_e state_q, state_d;
  exc_cause_e  cause_q, cause_d;
  logic        stopped_q, stopped_d;
  logic        run, viol, done;

  assign run  = (state_q == ST_NORMAL) && !stopped_q;
  // any privileged strobe in user mode is refused
  assign viol = run && !supv_i && (priv_instr_i | stop_exec_i | sr_wr_i | rte_i);
  assign done = (cause_q == CAUSE_RESET) ? reset_done_i : exc_done_i;

  always_comb begin
    state_d     = state_q;
    cause_d     = cause_q;
    stopped_d   = stopped_q;
    exc_enter_o = 1'b0;
    sr_load_o   = 1'b0;
    rte_load_o  = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (stopped_q) begin
          if (irq_i) begin
            stopped_d   = 1'b0;
            state_d     = ST_EXCEPT;
            cause_d     = CAUSE_OTHER;
            exc_enter_o = 1'b1;
          end
        end else if (bus_err_i) begin
          state_d     = ST_EXCEPT;
          cause_d     = CAUSE_BERR;
          exc_enter_o = 1'b1;
        end else if (viol || irq_i || trap_i) begin
          state_d     = ST_EXCEPT;
          cause_d     = CAUSE_OTHER;
          exc_enter_o = 1'b1;
        end else if (stop_exec_i) begin
          stopped_d = 1'b1;
        end else if (sr_wr_i) begin
          sr_load_o = 1'b1;
        end else if (rte_i) begin
          rte_load_o = 1'b1;
        end
      end
      ST_EXCEPT: begin
        if (bus_err_i) begin
          if (cause_q == CAUSE_OTHER) begin
            cause_d     = CAUSE_BERR;
            exc_enter_o = 1'b1;
          end else begin
            state_d = ST_HALTED;
          end
        end else if (done) begin
          state_d = ST_NORMAL;
        end
      end
      ST_HALTED: ;
      default: state_d = ST_HALTED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_EXCEPT;
      cause_q   <= CAUSE_RESET;
      stopped_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cause_q   <= cause_d;
      stopped_q <= stopped_d;
    end
  end

  assign state_o     = state_q;
  assign stopped_o   = stopped_q;
  assign priv_viol_o = viol;

  a_r5_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALTED |=> state_q == ST_HALTED);
  a_r6_stop_only_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_q |-> state_q == ST_NORMAL);
  a_r7_viol_enters_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o |=> state_q == ST_EXCEPT);
  a_r4_double_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXCEPT && cause_q != CAUSE_OTHER && bus_err_i) |=> state_q == ST_HALTED);
endmodule

// File: rtl/priv_mode_reg.sv
module priv_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exc_enter_i,
  input  logic sr_load_i,
  input  logic sr_val_i,
  input  logic rte_load_i,
  input  logic rte_val_i,
  output logic supv_o,
  output logic saved_s_o
);
  logic supv_q, saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      supv_q  <= 1'b1;
      saved_q <= 1'b1;
    end else if (exc_enter_i) begin
      saved_q <= supv_q;
      supv_q  <= 1'b1;
    end else if (sr_load_i) begin
      supv_q <= sr_val_i;
    end else if (rte_load_i) begin
      supv_q <= rte_val_i;
    end
  end

  assign supv_o    = supv_q;
  assign saved_s_o = saved_q;

  a_r3_entry_sets_supv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_enter_i |=> supv_q);
  a_r3_saved_prior: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_enter_i |=> saved_q == $past(supv_q));
  a_r8_user_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supv_q && !exc_enter_i) |=> !supv_q);
endmodule

// File: rtl/fc_encode.sv
module fc_encode
  import cpu_priv_pkg::*;
(
  input  logic             bus_valid_i,
  input  logic             quiet_i,
  input  logic             supv_i,
  input  logic [ACC_W-1:0] acc_kind_i,
  output logic [FC_W-1:0]  fc_o
);
  always_comb begin
    fc_o = FC_NONE;
    if (bus_valid_i && !quiet_i) begin
      unique case (acc_kind_e'(acc_kind_i))
        ACC_DATA: fc_o = supv_i ? FC_SDATA : FC_UDATA;
        ACC_PROG: fc_o = supv_i ? FC_SPROG : FC_UPROG;
        ACC_IACK: fc_o = FC_CPU;
        ACC_NONE: fc_o = FC_NONE;
        default:  fc_o = FC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_priv_ctrl.sv
module cpu_priv_ctrl
  import cpu_priv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_err_i,
  input  logic             irq_i,
  input  logic             trap_i,
  input  logic             stop_exec_i,
  input  logic             priv_instr_i,
  input  logic             sr_wr_i,
  input  logic             sr_wr_s_i,
  input  logic             rte_i,
  input  logic             rte_s_i,
  input  logic             reset_done_i,
  input  logic             exc_done_i,
  input  logic             bus_valid_i,
  input  logic [ACC_W-1:0] acc_kind_i,
  output logic [ST_W-1:0]  state_o,
  output logic             stopped_o,
  output logic             supv_o,
  output logic             saved_s_o,
  output logic             ssp_sel_o,
  output logic             priv_viol_o,
  output logic [FC_W-1:0]  fc_o,
  output logic             halted_o
);
  proc_state_e state;
  logic        stopped, supv, exc_enter, sr_load, rte_load, halted;

  priv_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supv_i       (supv),
    .bus_err_i    (bus_err_i),
    .irq_i        (irq_i),
    .trap_i       (trap_i),
    .stop_exec_i  (stop_exec_i),
    .priv_instr_i (priv_instr_i),
    .sr_wr_i      (sr_wr_i),
    .rte_i        (rte_i),
    .reset_done_i (reset_done_i),
    .exc_done_i   (exc_done_i),
    .state_o      (state),
    .stopped_o    (stopped),
    .priv_viol_o  (priv_viol_o),
    .exc_enter_o  (exc_enter),
    .sr_load_o    (sr_load),
    .rte_load_o   (rte_load)
  );

  priv_mode_reg u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_enter_i (exc_enter),
    .sr_load_i   (sr_load),
    .sr_val_i    (sr_wr_s_i),
    .rte_load_i  (rte_load),
    .rte_val_i   (rte_s_i),
    .supv_o      (supv),
    .saved_s_o   (saved_s_o)
  );

  assign halted = (state == ST_HALTED);

  fc_encode u_fc (
    .bus_valid_i (bus_valid_i),
    .quiet_i     (stopped | halted),
    .supv_i      (supv),
    .acc_kind_i  (acc_kind_i),
    .fc_o        (fc_o)
  );

  assign state_o   = state;
  assign stopped_o = stopped;
  assign supv_o    = supv;
  assign ssp_sel_o = supv;
  assign halted_o  = halted;

  a_r10_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_o != 3'b011 && fc_o != 3'b100);
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o || halted_o) |-> fc_o == FC_NONE);
  a_r3_exc_supv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_EXCEPT |-> supv_o);
endmodule

// File: tb/cpu_priv_ctrl_tb.sv
module cpu_priv_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_err = 0, irq = 0, trap = 0, stop_x = 0, priv_x = 0;
  logic sr_wr = 0, sr_s = 0, rte = 0, rte_s = 0, rdone = 0, edone = 0;
  logic valid = 0;
  logic [1:0] kind = 2'd0;
  logic [1:0] state_o;
  logic stopped_o, supv_o, saved_o, ssp_o, viol_o, halted_o;
  logic [2:0] fc_o;

  int vecs = 0, fails = 0;
  // model: state 0 normal, 1 exception, 2 halted; cause 0 reset, 1 bus error, 2 other
  int m_state, m_cause;
  bit m_stop, m_s, m_saved;

  always #10 clk = ~clk;

  cpu_priv_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_err_i(bus_err), .irq_i(irq), .trap_i(trap),
    .stop_exec_i(stop_x), .priv_instr_i(priv_x), .sr_wr_i(sr_wr), .sr_wr_s_i(sr_s),
    .rte_i(rte), .rte_s_i(rte_s), .reset_done_i(rdone), .exc_done_i(edone),
    .bus_valid_i(valid), .acc_kind_i(kind), .state_o(state_o), .stopped_o(stopped_o),
    .supv_o(supv_o), .saved_s_o(saved_o), .ssp_sel_o(ssp_o), .priv_viol_o(viol_o),
    .fc_o(fc_o), .halted_o(halted_o));

  function automatic bit e_viol();
    return m_state == 0 && !m_stop && !m_s && (priv_x || stop_x || sr_wr || rte);
  endfunction

  function automatic int e_fc();
    if (!valid || m_stop || m_state == 2) return 0;
    case (kind)
      2'd0: return m_s ? 5 : 1;
      2'd1: return m_s ? 6 : 2;
      2'd2: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic enter(int cause);
    m_saved = m_s;
    m_s = 1;
    m_state = 1;
    m_cause = cause;
  endtask

  task automatic model_step();
    bit v;
    v = e_viol();
    case (m_state)
      0: begin
        if (m_stop) begin
          if (irq) begin m_stop = 0; enter(2); end
        end else if (bus_err) enter(1);
        else if (v || irq || trap) enter(2);
        else if (stop_x) m_stop = 1;
        else if (sr_wr) m_s = sr_s;
        else if (rte) m_s = rte_s;
      end
      1: begin
        if (bus_err) begin
          if (m_cause == 2) enter(1); else m_state = 2;
        end else if (m_cause == 0 ? rdone : edone) m_state = 0;
      end
      default: ;
    endcase
  endtask

  task automatic model_reset();
    m_state = 1; m_cause = 0; m_stop = 0; m_s = 1; m_saved = 1;
  endtask

  task automatic clear_in();
    bus_err = 0; irq = 0; trap = 0; stop_x = 0; priv_x = 0;
    sr_wr = 0; rte = 0; rdone = 0; edone = 0;
  endtask

  // inputs are set at the falling edge by the caller
  task automatic cyc(string tag);
    #5;
    if (!rst_n) model_reset();
    cmp(tag, "state", int'(state_o), m_state);
    cmp(tag, "stopped", int'(stopped_o), int'(m_stop));
    cmp(tag, "supv", int'(supv_o), int'(m_s));
    cmp(tag, "saved_s", int'(saved_o), int'(m_saved));
    cmp("R9", "ssp_sel", int'(ssp_o), int'(m_s));
    cmp(tag, "priv_viol", int'(viol_o), int'(e_viol()));
    cmp(tag, "fc", int'(fc_o), e_fc());
    cmp(tag, "halted", int'(halted_o), int'(m_state == 2));
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    rst_n = 0; cyc("R1"); cyc("R1");
    rst_n = 1; cyc("R1");
    rdone = 1; cyc("R1");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    model_reset();
    @(negedge clk);
    // R1: reset values, exc_done ignored in reset sequence
    cyc("R1"); cyc("R1");
    rst_n = 1; cyc("R1");
    edone = 1; cyc("R1");
    rdone = 1; cyc("R1");
    // R10: supervisor codes
    valid = 1;
    for (int k = 0; k < 4; k++) begin kind = 2'(k); cyc("R10"); end
    valid = 0; kind = 2'd1; cyc("R10");
    valid = 1;
    // R8: drop to user by status write
    sr_wr = 1; sr_s = 0; cyc("R8");
    for (int k = 0; k < 4; k++) begin kind = 2'(k); cyc("R10"); end
    kind = 2'd1;
    // R7, R3: privileged instruction in user
    priv_x = 1; cyc("R7"); cyc("R3");
    edone = 1; cyc("R2");
    rte = 1; rte_s = 0; cyc("R8"); cyc("R8");
    sr_wr = 1; sr_s = 1; cyc("R7"); cyc("R3");
    edone = 1; cyc("R2");
    rte = 1; rte_s = 0; cyc("R8");
    stop_x = 1; cyc("R7"); cyc("R7");
    edone = 1; cyc("R2");
    rte = 1; rte_s = 0; cyc("R8");
    rte = 1; cyc("R7"); cyc("R7");
    edone = 1; cyc("R2");
    // R8: sr_wr wins over rte
    sr_wr = 1; sr_s = 1; rte = 1; rte_s = 0; cyc("R8"); cyc("R8");
    // R2: irq and trap in supervisor
    irq = 1; cyc("R2"); edone = 1; cyc("R2");
    trap = 1; cyc("R2"); rdone = 1; cyc("R2"); edone = 1; cyc("R2");
    // R6: stop, ignored events, irq wakes
    stop_x = 1; cyc("R6"); cyc("R6");
    trap = 1; cyc("R6"); bus_err = 1; cyc("R6");
    sr_wr = 1; sr_s = 0; cyc("R6"); priv_x = 1; cyc("R6");
    kind = 2'd2; cyc("R10"); kind = 2'd1;
    irq = 1; cyc("R6"); cyc("R6");
    edone = 1; cyc("R2");
    // R11: stop beats sr write; bus error beats irq
    stop_x = 1; sr_wr = 1; sr_s = 0; cyc("R11"); cyc("R11");
    irq = 1; cyc("R6"); edone = 1; cyc("R2");
    bus_err = 1; irq = 1; cyc("R11"); cyc("R11");
    // R4: second bus error halts
    bus_err = 1; cyc("R4"); cyc("R4");
    // R5: halted ignores everything
    irq = 1; edone = 1; rdone = 1; cyc("R5");
    kind = 2'd2; cyc("R5"); kind = 2'd1;
    stop_x = 1; trap = 1; cyc("R5"); cyc("R5");
    do_reset();
    // R4: bus error during another exception converts, then halts
    irq = 1; cyc("R4"); bus_err = 1; cyc("R4"); cyc("R4");
    bus_err = 1; cyc("R4"); cyc("R5");
    // R4: bus error during reset sequence halts
    rst_n = 0; cyc("R1"); rst_n = 1; cyc("R1");
    bus_err = 1; cyc("R4"); cyc("R4");
    do_reset();
    // R11: user-mode violation with irq still enters exception once
    sr_wr = 1; sr_s = 0; cyc("R8");
    priv_x = 1; irq = 1; cyc("R11"); cyc("R3");
    edone = 1; cyc("R2");
    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (m_state == 2) begin
        rst_n = 0; cyc("R1"); rst_n = 1;
      end
      bus_err = (lfsr[3:0] == 4'h0);
      irq = (lfsr[6:4] == 3'd0);
      trap = (lfsr[9:7] == 3'd1);
      stop_x = (lfsr[12:10] == 3'd2);
      priv_x = (lfsr[14:12] == 3'd3);
      sr_wr = lfsr[1] & lfsr[5];
      sr_s = lfsr[8];
      rte = lfsr[2] & lfsr[9];
      rte_s = lfsr[11];
      rdone = lfsr[4];
      edone = lfsr[7] | lfsr[15];
      valid = lfsr[0] | lfsr[14];
      kind = lfsr[13:12];
      cyc("R11");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule